// File: doc/BRIEF.md
# Translation Cache with Global-Entry Selective Flush

A small fully associative cache of linear-to-physical page translations. Each entry maps one page of a 32-bit linear space onto a 36-bit physical space. The page is either 4 KB or 2 MB. A page walker writes new translations through a fill port. Address consumers present a linear address on the lookup port and get a hit flag and a physical address back in the same cycle.

Loading the page-table base register invalidates cached entries. The load can come from an explicit write or from a task switch. Bit 7 of the feature control input selects the flush policy. When that bit is clear, every entry is dropped. When it is set, entries marked global survive. Fills go to the lowest free slot, or to a round-robin victim when the cache is full.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid, so every lookup reports a miss.
- R2: A valid 4 KB entry (size flag 0) hits when linear bits [31:12] equal its tag. The physical address is then {frame[23:0], linear[11:0]}.
- R3: A valid 2 MB entry (size flag 1) hits when linear bits [31:21] equal tag bits [19:9]. The physical address is then {frame[23:9], linear[20:0]}, so linear bits [20:0] pass straight through.
- R4: When at least one entry is invalid, a fill writes the lowest-numbered invalid entry. The replacement pointer does not move.
- R5: When all entries are valid, a fill overwrites the entry at the replacement pointer. The pointer starts at 0 after reset and advances by one, wrapping, on each such replacement only.
- R6: A base-register write with feature bit 7 clear invalidates every entry.
- R7: A base-register write with feature bit 7 set invalidates exactly the entries whose global flag is 0.
- R8: A task switch applies the same flush policy as a base-register write.
- R9: A fill in the same cycle as a flush is discarded. The flush alone takes effect.
- R10: A lookup in the cycle in which a flush is applied reports a miss, even for an entry that survives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_lin | input | 32 | Lookup linear address |
| lk_hit | output | 1 | Lookup hit, combinational |
| lk_phys | output | 36 | Translated physical address, valid with lk_hit |
| fill_en | input | 1 | Write a new translation |
| fill_lin | input | 32 | Linear address of the filled page |
| fill_frame | input | 24 | Physical frame number (physical bits [35:12]) |
| fill_big | input | 1 | 1 = 2 MB page, 0 = 4 KB page |
| fill_glob | input | 1 | Global flag of the filled entry |
| base_wr | input | 1 | Explicit write of the page-table base register |
| task_sw | input | 1 | Task switch, which loads the base register implicitly |
| feat_ctl | input | 32 | Feature control register; bit 7 enables global retention |

## Verification
The hardest state to reach is a full cache with a partly advanced replacement pointer, after a selective flush has left holes between global survivors. In that state a fill must choose a hole rather than the pointer slot. The stimulus reaches it with a four-entry configuration. It fills to capacity, forces two replacements, applies a selective flush, refills the holes and replaces once more. After every step it sweeps lookups over every page ever filled and over its neighbours, and compares them against a reference model held in the bench.

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int ENTRIES  = 8,
  parameter int PA_W     = 36,
  parameter int GLOB_BIT = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [31:0]     lk_lin,
  output logic            lk_hit,
  output logic [PA_W-1:0] lk_phys,
  input  logic            fill_en,
  input  logic [31:0]     fill_lin,
  input  logic [PA_W-13:0] fill_frame,
  input  logic            fill_big,
  input  logic            fill_glob,
  input  logic            base_wr,
  input  logic            task_sw,
  input  logic [31:0]     feat_ctl
);
  localparam int FR_W  = PA_W - 12;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] v_q, g_q, big_q, match;
  logic [19:0]        tag_q [ENTRIES];
  logic [FR_W-1:0]    fr_q  [ENTRIES];
  logic [IDX_W-1:0]   rr_q, hit_idx, free_idx, victim;
  logic               any_match, any_free;

  wire flush = base_wr | task_sw;
  wire gen   = feat_ctl[GLOB_BIT];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i] = v_q[i] && (big_q[i] ? tag_q[i][19:9] == lk_lin[31:21]
                                          : tag_q[i] == lk_lin[31:12]);
  end

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = IDX_W'(i);
      if (!v_q[i])  free_idx = IDX_W'(i);
    end
  end

  assign any_match = |match;
  assign any_free  = ~&v_q;
  assign victim    = any_free ? free_idx : rr_q;
  assign lk_hit    = any_match & ~flush;
  assign lk_phys   = big_q[hit_idx] ? {fr_q[hit_idx][FR_W-1:9], lk_lin[20:0]}
                                    : {fr_q[hit_idx], lk_lin[11:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q  <= '0;
      rr_q <= '0;
    end else if (flush) begin
      v_q <= gen ? (v_q & g_q) : '0;
    end else if (fill_en) begin
      v_q[victim]   <= 1'b1;
      g_q[victim]   <= fill_glob;
      big_q[victim] <= fill_big;
      tag_q[victim] <= fill_lin[31:12];
      fr_q[victim]  <= fill_frame;
      if (!any_free)
        rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

module xlat_cache_chk #(parameter int N = 8) (
  input logic         clk,
  input logic         rst_n,
  input logic         flush,
  input logic         gen,
  input logic         fill_en,
  input logic [N-1:0] valid,
  input logic [N-1:0] glob,
  input logic         hit
);
  // R6
  all_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !gen) |=> (valid == '0));
  // R7
  glob_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && gen) |=> (valid == ($past(valid) & $past(glob))));
  // R9
  fill_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && fill_en) |=> ($countones(valid) <= $countones($past(valid))));
  // R10
  flush_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !hit);
  // R4
  fill_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush && !(&valid)) |=> ($countones(valid) == $countones($past(valid)) + 1));
endmodule

bind xlat_cache xlat_cache_chk #(.N(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .gen(gen), .fill_en(fill_en),
  .valid(v_q), .glob(g_q), .hit(lk_hit)
);

// File: tb/xlat_cache_bench.sv
module xlat_cache_bench;
  localparam int NE = 4;

  logic        clk = 0, rst_n = 0;
  logic [31:0] lk_lin = 0, fill_lin = 0, feat_ctl = 0;
  logic [23:0] fill_frame = 0;
  logic        fill_en = 0, fill_big = 0, fill_glob = 0, base_wr = 0, task_sw = 0;
  logic        lk_hit;
  logic [35:0] lk_phys;

  int checks = 0, errors = 0;
  bit done = 0;

  logic        m_v [NE], m_g [NE], m_big [NE];
  logic [19:0] m_tag [NE];
  logic [23:0] m_fr [NE];
  int          m_rr = 0;
  logic [31:0] hist [64];
  int          nhist = 0;

  xlat_cache #(.ENTRIES(NE)) u_xlat_cache (
    .clk(clk), .rst_n(rst_n), .lk_lin(lk_lin), .lk_hit(lk_hit), .lk_phys(lk_phys),
    .fill_en(fill_en), .fill_lin(fill_lin), .fill_frame(fill_frame),
    .fill_big(fill_big), .fill_glob(fill_glob), .base_wr(base_wr),
    .task_sw(task_sw), .feat_ctl(feat_ctl));

  always #10 clk = ~clk;

  task automatic probe(input logic [31:0] a, input string miss_req);
    logic eh = 0;
    logic [35:0] ep = 0;
    string r = miss_req;
    for (int i = NE - 1; i >= 0; i--)
      if (m_v[i] && (m_big[i] ? m_tag[i][19:9] == a[31:21] : m_tag[i] == a[31:12])) begin
        eh = 1;
        if (m_big[i]) begin ep = {m_fr[i][23:9], a[20:0]}; r = "R3"; end
        else          begin ep = {m_fr[i], a[11:0]};       r = "R2"; end
      end
    lk_lin = a;
    #1;
    checks++;
    if (lk_hit !== eh || (eh && lk_phys !== ep)) begin
      errors++;
      $display("FAIL %s lin=%h got hit=%b phys=%h expected hit=%b phys=%h",
               r, a, lk_hit, lk_phys, eh, ep);
    end
  endtask

  task automatic sweep(input string miss_req);
    for (int k = 0; k < nhist; k++) begin
      probe(hist[k], miss_req);
      probe(hist[k] ^ 32'h0000_0ABC, miss_req);
      probe(hist[k] ^ 32'h001F_F123, miss_req);
      probe(hist[k] + 32'h0000_1000, miss_req);
      probe(hist[k] + 32'h0020_0000, miss_req);
    end
  endtask

  task automatic do_fill(input logic [31:0] a, input logic [23:0] f, input bit big, input bit g);
    int vi = -1;
    for (int i = NE - 1; i >= 0; i--) if (!m_v[i]) vi = i;
    fill_en = 1; fill_lin = a; fill_frame = f; fill_big = big; fill_glob = g;
    @(posedge clk); #1;
    fill_en = 0;
    if (vi < 0) begin vi = m_rr; m_rr = (m_rr + 1) % NE; end
    m_v[vi] = 1; m_g[vi] = g; m_big[vi] = big; m_tag[vi] = a[31:12]; m_fr[vi] = f;
    hist[nhist] = a; nhist++;
  endtask

  task automatic do_flush(input bit ts, input bit gen, input bit with_fill, input string req);
    base_wr = !ts; task_sw = ts; feat_ctl = gen ? 32'h0000_0080 : 32'h0000_0000;
    fill_en = with_fill; fill_lin = 32'h5555_5000; fill_frame = 24'hEEE555;
    fill_big = 0; fill_glob = 1;
    for (int k = 0; k < nhist; k++) begin
      lk_lin = hist[k]; #1;
      checks++;
      if (lk_hit !== 1'b0) begin
        errors++;
        $display("FAIL R10 lin=%h got hit=%b expected hit=0 during flush", hist[k], lk_hit);
      end
    end
    @(posedge clk); #1;
    base_wr = 0; task_sw = 0; fill_en = 0;
    for (int i = 0; i < NE; i++) if (!gen || !m_g[i]) m_v[i] = 0;
    if (with_fill) begin hist[nhist] = 32'h5555_5000; nhist++; end
    sweep(req);
  endtask

  initial begin
    for (int i = 0; i < NE; i++) begin m_v[i] = 0; m_g[i] = 0; m_big[i] = 0; m_tag[i] = 0; m_fr[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    hist[0] = 32'h0000_1000; hist[1] = 32'hFFFF_F000; nhist = 2;
    sweep("R1");
    // R2 R3 R4: fill to capacity, mixed sizes
    do_fill(32'h0000_1000, 24'h900001, 0, 1);
    do_fill(32'h1234_5000, 24'hA00002, 0, 0);
    do_fill(32'h8060_0ABC, 24'hF12345, 1, 1);
    do_fill(32'hFFFF_F000, 24'h700004, 0, 0);
    sweep("R4");
    // R5: two replacements at the pointer
    do_fill(32'h4020_0000, 24'hB00005, 1, 0);
    sweep("R5");
    do_fill(32'h0000_2000, 24'hC00006, 0, 0);
    sweep("R5");
    // R7 R10: selective flush keeps global survivor
    do_flush(0, 1, 0, "R7");
    // R4: holes filled lowest-first, then R5 replacement at pointer 2
    do_fill(32'h7FE0_0000, 24'hD00007, 1, 0);
    do_fill(32'h3333_3000, 24'hE00008, 0, 1);
    do_fill(32'hC000_0000, 24'h100009, 1, 0);
    sweep("R4");
    do_fill(32'h6666_6000, 24'h20000A, 0, 0);
    sweep("R5");
    // R8: task switch with global mode keeps globals
    do_flush(1, 1, 0, "R8");
    // R9: fill together with flush is discarded
    do_flush(0, 1, 1, "R9");
    // R6: full flush with global mode off, also via task switch (R8)
    do_fill(32'h0ABC_D000, 24'h30000B, 0, 1);
    do_flush(0, 0, 0, "R6");
    do_fill(32'h1357_9000, 24'h40000C, 1, 1);
    do_flush(1, 0, 1, "R8");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule